// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two bidirectional 8-bit buses, called A and B here. Each direction has its own storage register, clock, source select and output enable. The register for the A-to-B direction samples bus A on a rising edge of its clock. The register for the B-to-A direction samples bus B on a rising edge of its own clock. Sampling takes place on every rising edge, whatever the selects and enables are doing.

For each direction, the select picks what the driven port shows: either the live value of the opposite bus or the value held in that direction's register. The enable for the A-to-B direction is active high. The enable for the B-to-A direction is active low.

Inside a synthesizable design a bus cannot be a true tri-state net, so each port is split into an input vector, an output vector and an output-enable flag. The surrounding fabric, or here the testbench, resolves the real lines. With both directions enabled and both selects on live data, each bus feeds back through the block onto itself. If no other source drives the buses, they then keep their last value. The block is driven by plain control pins; it carries no stream data, so it has no valid/ready handshake.

Top module: `bus_xcvr_reg`

## Requirements
- R1: An active-high `rst` sampled on a rising edge of a direction's clock clears that direction's register to zero.
- R2: On a rising edge of `clk_ab` (with `rst` low), the A-to-B register takes the value present on `a_in`.
- R3: On a rising edge of `clk_ba` (with `rst` low), the B-to-A register takes the value present on `b_in`.
- R4: Register capture depends on neither the select inputs nor the enable inputs.
- R5: When `sel_ab` is 0, `b_out` equals the live `a_in`. When `sel_ab` is 1, `b_out` equals the A-to-B register.
- R6: When `sel_ba` is 0, `a_out` equals the live `b_in`. When `sel_ba` is 1, `a_out` equals the B-to-A register.
- R7: `b_oe` is 1 exactly when `en_ab` is 1 (active high). `a_oe` is 1 exactly when `en_ba_n` is 0 (active low).
- R8: With `en_ab`=0 and `en_ba_n`=1, neither port drives, and both registers still capture on their clock edges.
- R9: With both selects 0 and both ports enabled, each port drives back the value of the opposite bus. Once external drivers release, both buses hold their last value.
- R10: While the B port drives live A data, a `clk_ba` edge loads that A data into the B-to-A register. A `clk_ab` edge in the same state loads it into the A-to-B register too.
- R11: A register keeps its value between rising edges of its own clock, even when its bus input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high clear, sampled by each clock |
| sel_ab | input | 1 | B port source: 0 live A, 1 stored A |
| sel_ba | input | 1 | A port source: 0 live B, 1 stored B |
| en_ab | input | 1 | B port drive enable, active high |
| en_ba_n | input | 1 | A port drive enable, active low |
| a_in | input | 8 | Resolved value of bus A |
| a_out | output | 8 | Value the block places on bus A |
| a_oe | output | 1 | Block drives bus A |
| b_in | input | 8 | Resolved value of bus B |
| b_out | output | 8 | Value the block places on bus B |
| b_oe | output | 1 | Block drives bus B |

## Verification
A wrong register value stays invisible while its select is 0. It shows on the opposite port as soon as that select is 1, with no added latency, because the output path is purely combinational. A fault in the live path or in an enable polarity shows at the ports in the same cycle the input changes. A fault in the live path also breaks the bus-hold loop: the held bus value drifts away from its last driven value one settle after the external drivers release.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int XCVR_WIDTH = 8;
  localparam int XCVR_DIRS  = 2;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive
  import xcvr_pkg::*;
#(
  parameter int WIDTH         = 8,
  parameter bit EN_ACTIVE_LOW = 1'b0
) (
  input  logic             sel,
  input  logic             en,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] dout,
  output logic             oe
);
  src_sel_e src;
  assign src = src_sel_e'(sel);

  always_comb begin
    unique case (src)
      SRC_STORED: dout = stored;
      default:    dout = live;
    endcase
  end

  generate
    if (EN_ACTIVE_LOW) begin : g_low
      assign oe = ~en;
    end else begin : g_high
      assign oe = en;
    end
  endgenerate
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int WIDTH = XCVR_WIDTH
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             en_ab,
  input  logic             en_ba_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  localparam int NDIR    = XCVR_DIRS;
  localparam int DIR_AB  = 0;
  localparam int DIR_BA  = 1;

  logic             clk_v    [NDIR];
  logic             sel_v    [NDIR];
  logic             en_v     [NDIR];
  logic [WIDTH-1:0] src_v    [NDIR];
  logic [WIDTH-1:0] stored_v [NDIR];
  logic [WIDTH-1:0] out_v    [NDIR];
  logic             oe_v     [NDIR];

  assign clk_v[DIR_AB] = clk_ab;
  assign clk_v[DIR_BA] = clk_ba;
  assign sel_v[DIR_AB] = sel_ab;
  assign sel_v[DIR_BA] = sel_ba;
  assign en_v[DIR_AB]  = en_ab;
  assign en_v[DIR_BA]  = en_ba_n;
  assign src_v[DIR_AB] = a_in;
  assign src_v[DIR_BA] = b_in;

  // One capture register and one output path per direction; the B-to-A
  // enable is the active-low one.
  generate
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      xcvr_store #(.WIDTH(WIDTH)) u_store (
        .clk (clk_v[d]),
        .rst (rst),
        .d   (src_v[d]),
        .q   (stored_v[d])
      );
      xcvr_drive #(.WIDTH(WIDTH), .EN_ACTIVE_LOW(d == DIR_BA)) u_drive (
        .sel    (sel_v[d]),
        .en     (en_v[d]),
        .live   (src_v[d]),
        .stored (stored_v[d]),
        .dout   (out_v[d]),
        .oe     (oe_v[d])
      );
    end
  endgenerate

  assign b_out = out_v[DIR_AB];
  assign b_oe  = oe_v[DIR_AB];
  assign a_out = out_v[DIR_BA];
  assign a_oe  = oe_v[DIR_BA];
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_ab,
  input logic             clk_ba,
  input logic             rst,
  input logic             sel_ab,
  input logic             sel_ba,
  input logic             en_ab,
  input logic             en_ba_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic [WIDTH-1:0] reg_ab,
  input logic [WIDTH-1:0] reg_ba
);
  assert_capture_a_R2: assert property (@(posedge clk_ab) disable iff (rst)
    !$isunknown(a_in) |=> (reg_ab == $past(a_in)));

  assert_capture_b_R3: assert property (@(posedge clk_ba) disable iff (rst)
    !$isunknown(b_in) |=> (reg_ba == $past(b_in)));

  assert_isolated_capture_R8: assert property (@(posedge clk_ab) disable iff (rst)
    (!en_ab && en_ba_n) |=> (reg_ab == $past(a_in)));

  assert_b_stored_R5: assert property (@(posedge clk_ab) disable iff (rst)
    sel_ab |-> (b_out == reg_ab));

  assert_a_stored_R6: assert property (@(posedge clk_ba) disable iff (rst)
    sel_ba |-> (a_out == reg_ba));

  assert_loop_R9: assert property (@(posedge clk_ab) disable iff (rst)
    (a_oe && b_oe && !sel_ab && !sel_ba) |-> (b_out == a_in && a_out == b_in));

  assert_cross_store_R10: assert property (@(posedge clk_ba) disable iff (rst)
    (b_oe && !sel_ab) |=> (reg_ba == $past(b_out)));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_ab  (clk_ab),
  .clk_ba  (clk_ba),
  .rst     (rst),
  .sel_ab  (sel_ab),
  .sel_ba  (sel_ba),
  .en_ab   (en_ab),
  .en_ba_n (en_ba_n),
  .a_in    (a_in),
  .a_out   (a_out),
  .a_oe    (a_oe),
  .b_in    (b_in),
  .b_out   (b_out),
  .b_oe    (b_oe),
  .reg_ab  (stored_v[0]),
  .reg_ba  (stored_v[1])
);

// File: tb/bus_xcvr_reg_bench.sv
module bus_xcvr_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk_ab = 1'b0, clk_ba = 1'b0, rst = 1'b1;
  logic sel_ab = 1'b0, sel_ba = 1'b0, en_ab = 1'b0, en_ba_n = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  // Bus model: external drivers plus keepers
  logic ext_a_en = 1'b0, ext_b_en = 1'b0;
  logic [W-1:0] ext_a_val = '0, ext_b_val = '0;
  logic [W-1:0] a_bus = '0, b_bus = '0;
  // Reference registers
  logic [W-1:0] ref_ab = '0, ref_ba = '0;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  bus_xcvr_reg u_bus_xcvr_reg (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic cmp(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Resolve both buses; a port with nobody driving keeps its last value.
  task automatic settle();
    for (int i = 0; i < 4; i++) begin
      #1;
      if (ext_a_en) a_bus = ext_a_val; else if (a_oe) a_bus = a_out;
      if (ext_b_en) b_bus = ext_b_val; else if (b_oe) b_bus = b_out;
      a_in = a_bus;
      b_in = b_bus;
    end
    if ((ext_a_en && a_oe) || (ext_b_en && b_oe)) begin
      tests++; fails++;
      $display("FAIL R7 contention a_oe=%0b b_oe=%0b expected no overlap with external driver", a_oe, b_oe);
    end
  endtask

  // Whole-port comparison against the behavioural model
  task automatic chk(input string tag);
    logic [W-1:0] exp_b, exp_a;
    settle();
    exp_b = sel_ab ? ref_ab : a_bus;
    exp_a = sel_ba ? ref_ba : b_bus;
    cmp(tag, "b_out", b_out, exp_b);
    cmp(tag, "a_out", a_out, exp_a);
    cmp({tag, "/R7"}, "b_oe", {7'd0, b_oe}, {7'd0, en_ab});
    cmp({tag, "/R7"}, "a_oe", {7'd0, a_oe}, {7'd0, !en_ba_n});
  endtask

  task automatic pulse(input bit do_ab, input bit do_ba, input string tag);
    settle();
    if (do_ab) ref_ab = rst ? '0 : a_bus;
    if (do_ba) ref_ba = rst ? '0 : b_bus;
    if (do_ab) clk_ab = 1'b1;
    if (do_ba) clk_ba = 1'b1;
    #(CLK_PERIOD / 2);
    chk(tag);
    clk_ab = 1'b0;
    clk_ba = 1'b0;
    #(CLK_PERIOD / 2);
    chk(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset clears both registers
    rst = 1'b1;
    pulse(1, 1, "R1");
    rst = 1'b0;
    sel_ab = 1'b1; sel_ba = 1'b1; en_ab = 1'b1; en_ba_n = 1'b0;
    chk("R1");
    cmp("R1", "b_out", b_out, 8'h00);
    cmp("R1", "a_out", a_out, 8'h00);

    // R8/R4: isolation, capture still works
    en_ab = 1'b0; en_ba_n = 1'b1;
    ext_a_en = 1'b1; ext_a_val = 8'h5A;
    ext_b_en = 1'b1; ext_b_val = 8'hC3;
    pulse(1, 1, "R8");
    cmp("R8", "b_oe", {7'd0, b_oe}, 8'h00);
    cmp("R8", "a_oe", {7'd0, a_oe}, 8'h00);
    ext_a_en = 1'b0; ext_b_en = 1'b0;
    en_ab = 1'b1; en_ba_n = 1'b0;
    chk("R4");
    cmp("R4", "b_out", b_out, 8'h5A);
    cmp("R4", "a_out", a_out, 8'hC3);

    // R5/R11: live A to B, register held without an edge
    en_ba_n = 1'b1; sel_ab = 1'b0;
    ext_a_en = 1'b1; ext_a_val = 8'h11;
    chk("R5");
    ext_a_val = 8'h22;
    chk("R5");
    cmp("R5", "b_out", b_out, 8'h22);
    sel_ab = 1'b1;
    chk("R11");
    cmp("R11", "b_out", b_out, 8'h5A);

    // R2: capture A
    pulse(1, 0, "R2");
    cmp("R2", "b_out", b_out, 8'h22);

    // R10: B driven from A, clk_ba stores A data in the B-to-A register
    sel_ab = 1'b0; ext_a_val = 8'h3C;
    pulse(0, 1, "R10");
    pulse(1, 0, "R10");
    ext_a_en = 1'b0; en_ab = 1'b0; en_ba_n = 1'b0; sel_ba = 1'b1;
    chk("R10");
    cmp("R10", "a_out", a_out, 8'h3C);

    // R6/R3: live and stored B to A
    en_ba_n = 1'b1; ext_b_en = 1'b1; ext_b_val = 8'h77;
    ext_a_en = 1'b1; ext_a_val = 8'h00;
    sel_ba = 1'b0;
    chk("R6");
    cmp("R6", "a_out", a_out, 8'h77);
    sel_ba = 1'b1;
    chk("R6");
    pulse(0, 1, "R3");
    cmp("R3", "a_out", a_out, 8'h77);

    // R9: both live, both enabled, bus hold after release
    ext_b_en = 1'b0; ext_a_val = 8'h99;
    sel_ab = 1'b0; sel_ba = 1'b0; en_ab = 1'b1;
    chk("R9");
    ext_a_en = 1'b0; en_ba_n = 1'b0;
    chk("R9");
    pulse(1, 1, "R9");
    cmp("R9", "a_bus", a_bus, 8'h99);
    cmp("R9", "b_bus", b_bus, 8'h99);

    // R1: reset one direction only
    en_ab = 1'b0; en_ba_n = 1'b1;
    rst = 1'b1;
    pulse(1, 0, "R1");
    rst = 1'b0;
    sel_ab = 1'b1; sel_ba = 1'b1; en_ab = 1'b1; en_ba_n = 1'b0;
    chk("R1");
    cmp("R1", "b_out", b_out, 8'h00);
    cmp("R1", "a_out", a_out, 8'h99);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule